// File: doc/BRIEF.md
# Complementary Output Pair with Dead Time and Break

This block is the output stage of one channel of an advanced PWM timer. It takes a single reference waveform and drives a high-side/low-side pair of pins. When the reference changes, the pin being switched off drops first and the pin being switched on waits a programmable number of clock cycles. This keeps a power half-bridge from shooting through. A per-pin polarity bit and an output-mode field set the level each pin shows for a given reference.

A main output enable gates the whole pair. Software sets and clears it. A break input that is enabled and active clears it at once, through a combinational path to the pins, and latches a sticky break flag. With automatic re-arm set, the next update event restores the main enable, provided the break has gone away. While the main enable is low, pins whose channel enable is set either go to their idle levels or are released. The idle-state select decides which. A pin with a partner reaches its idle level only after the dead time. While the main enable is high, the run-state select decides whether a disabled pin drives its inactive level or is released.

All configuration arrives as one 24-bit word. A lock level written into that word freezes groups of fields against later writes. The lock level itself is taken only from the first configuration write after reset.

Top module: `cpair_out_stage`

## Requirements
- R1: After reset both pin enables, both pins, `main_en` and `brk_flag` are 0, the lock level is 0 and every configuration field is 0.
- R2: A write with `cfg_we` high loads `cfg_wdata` at the next clock edge. The field positions are:
  - [7:0] dead time
  - [8] break enable
  - [9] break polarity (1 = active high)
  - [10] automatic re-arm
  - [11] idle level of pin P
  - [12] idle level of pin N
  - [13] polarity of pin P (1 = active low)
  - [14] polarity of pin N
  - [15] run-state off select
  - [16] idle-state off select
  - [17] direct (no dead time)
  - [19:18] lock level
  - [20] enable of pin P
  - [21] enable of pin N
  - [23:22] output mode
- R3: With dead time D and direct at 0, a reference change switches the active pin off at the next clock edge and switches the other pin on D edges later. With D = 0 both switch at the same edge. The two pins are never active together.
- R4: With direct at 1, both pins follow a reference change at the next edge with no gap.
- R5: With the main enable high and the pin enabled, the pin shows its active state XOR its polarity bit, so the inactive level equals the polarity bit.
- R6: The output mode selects the internal reference:
  - 00: follow `ref_in`
  - 01: inverted `ref_in`
  - 10: forced inactive
  - 11: forced active
- R7: When the break is enabled and `brk_in` equals the break polarity bit, `main_en` is 0 in the same cycle and `brk_flag` is 1 after the next edge. The flag stays 1 until `flag_clr` is applied with the break inactive. With break enable at 0, `brk_in` has no effect.
- R8: `moe_set` sets `main_en` at the next edge. With automatic re-arm set, `upd_evt` also sets it, but only if the break is inactive. With automatic re-arm clear, `upd_evt` has no effect.
- R9: With `main_en` 0, the idle-state select at 1 and the pin enabled, the pin is driven (enable 1). It shows its inactive level until D+1 edges after `main_en` fell, then its idle level. With the idle-state select at 0 the pin is released (enable 0).
- R10: With `main_en` 1 and the pin's enable at 0, the run-state select at 1 drives the pin's inactive level with its enable at 1. The run-state select at 0 releases the pin.
- R11: Fields frozen against writes, by lock level; pin enables and direct are never frozen:
  - level 1 or above: dead time, break enable, break polarity, automatic re-arm, idle levels
  - level 2 or above: adds the polarities and both off selects
  - level 3: adds the output mode
- R12: Only the first configuration write after reset loads the lock level; later writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference waveform |
| upd_evt | input | 1 | Update event pulse |
| brk_in | input | 1 | Break input |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 24 | Configuration word |
| moe_set | input | 1 | Software set of main enable |
| moe_clr | input | 1 | Software clear of main enable |
| flag_clr | input | 1 | Clear break flag |
| pin_p | output | 1 | High-side pin level |
| pin_n | output | 1 | Low-side pin level |
| pin_p_oe | output | 1 | High-side pin drive enable |
| pin_n_oe | output | 1 | Low-side pin drive enable |
| main_en | output | 1 | Effective main output enable |
| brk_flag | output | 1 | Sticky break flag |

## Verification
A configuration write, `moe_set`, `moe_clr` and `upd_evt` each act at the first edge after they are driven. The break drops `main_en` without waiting for an edge, and the flag follows one edge later. A reference change reaches the off-going pin one edge later and the on-going pin D edges after that. Idle levels appear D+1 edges after the main enable falls. The bench drives and samples 5 ns after each rising edge and counts edges explicitly. Each on-going pin is sampled one cycle before and at its due edge, so that an early or late switch is caught. The break's same-cycle effect is sampled 1 ns after `brk_in` moves, before any edge.

// File: rtl/cpo_pkg.sv
// Shared types for the complementary output stage.
// Assumes a fixed 24-bit configuration word; field order matches the brief.
package cpo_pkg;

    localparam int DT_W = 8;

    localparam logic [1:0] LOCK_NONE = 2'd0;
    localparam logic [1:0] LOCK_L1   = 2'd1;
    localparam logic [1:0] LOCK_L2   = 2'd2;
    localparam logic [1:0] LOCK_L3   = 2'd3;

    typedef enum logic [1:0] {
        MODE_FOLLOW    = 2'b00,
        MODE_INVERT    = 2'b01,
        MODE_FORCE_OFF = 2'b10,
        MODE_FORCE_ON  = 2'b11
    } ref_mode_e;

    typedef struct packed {
        ref_mode_e       mode;      // 23:22
        logic            en_n;      // 21
        logic            en_p;      // 20
        logic [1:0]      lock;      // 19:18
        logic            direct;    // 17
        logic            off_idle;  // 16
        logic            off_run;   // 15
        logic            pol_n;     // 14
        logic            pol_p;     // 13
        logic            idle_n;    // 12
        logic            idle_p;    // 11
        logic            auto_arm;  // 10
        logic            brk_pol;   // 9
        logic            brk_en;    // 8
        logic [DT_W-1:0] dt;        // 7:0
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/cpo_cfg_regs.sv
// Configuration register with lock masking.
// The lock level is captured from the first write after reset only; each
// later write is masked field by field using the lock level already held.
module cpo_cfg_regs
    import cpo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  cfg_t wdata,
    output cfg_t cfg
);

    cfg_t cfg_q;
    cfg_t cfg_nxt;
    logic lock_taken;

    // Merge the incoming word with the frozen fields of the held word.
    always_comb begin
        cfg_nxt      = wdata;
        cfg_nxt.lock = lock_taken ? cfg_q.lock : wdata.lock;
        if (cfg_q.lock >= LOCK_L1) begin
            cfg_nxt.dt       = cfg_q.dt;
            cfg_nxt.brk_en   = cfg_q.brk_en;
            cfg_nxt.brk_pol  = cfg_q.brk_pol;
            cfg_nxt.auto_arm = cfg_q.auto_arm;
            cfg_nxt.idle_p   = cfg_q.idle_p;
            cfg_nxt.idle_n   = cfg_q.idle_n;
        end
        if (cfg_q.lock >= LOCK_L2) begin
            cfg_nxt.pol_p    = cfg_q.pol_p;
            cfg_nxt.pol_n    = cfg_q.pol_n;
            cfg_nxt.off_run  = cfg_q.off_run;
            cfg_nxt.off_idle = cfg_q.off_idle;
        end
        if (cfg_q.lock == LOCK_L3) begin
            cfg_nxt.mode = cfg_q.mode;
        end
    end

    // Hold the configuration and note that the lock level has been taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            lock_taken <= 1'b0;
        end else if (we) begin
            cfg_q      <= cfg_nxt;
            lock_taken <= 1'b1;
        end
    end

    assign cfg = cfg_q;

    AST_LOCK_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_taken |=> $stable(cfg_q.lock)); // R12

endmodule

// File: rtl/cpo_moe_ctrl.sv
// Main output enable, break detection, break flag and idle dead-time tracking.
// The break acts combinationally on the effective enable; the flag and the
// held enable update at the clock edge. idle_wait stays high from the cycle
// the effective enable falls until the dead time has elapsed.
module cpo_moe_ctrl #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            brk_in,
    input  logic            brk_en,
    input  logic            brk_pol,
    input  logic            auto_arm,
    input  logic            upd_evt,
    input  logic            moe_set,
    input  logic            moe_clr,
    input  logic            flag_clr,
    input  logic [DT_W-1:0] dt,
    output logic            moe_eff,
    output logic            brk_flag,
    output logic            idle_wait
);

    logic            brk_act;
    logic            moe_q;
    logic            moe_nxt;
    logic            run_q;
    logic [DT_W-1:0] idle_cnt;

    // Break is active when enabled and the pin matches the selected polarity.
    assign brk_act = brk_en & (brk_in ~^ brk_pol);
    assign moe_eff = moe_q & ~brk_act;

    // Priority: break, software clear, software set, automatic re-arm.
    always_comb begin
        moe_nxt = moe_q;
        if (brk_act)                   moe_nxt = 1'b0;
        else if (moe_clr)              moe_nxt = 1'b0;
        else if (moe_set)              moe_nxt = 1'b1;
        else if (auto_arm && upd_evt)  moe_nxt = 1'b1;
    end

    // Register the enable and the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            moe_q    <= 1'b0;
            brk_flag <= 1'b0;
        end else begin
            moe_q <= moe_nxt;
            if (brk_act)       brk_flag <= 1'b1;
            else if (flag_clr) brk_flag <= 1'b0;
        end
    end

    // Count the dead time after the effective enable falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            idle_cnt <= '0;
        end else begin
            run_q <= moe_eff;
            if (moe_eff)              idle_cnt <= '0;
            else if (run_q)           idle_cnt <= dt;
            else if (idle_cnt != '0)  idle_cnt <= idle_cnt - 1'b1;
        end
    end

    assign idle_wait = run_q | (idle_cnt != '0);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag && !flag_clr) |=> brk_flag); // R7

    AST_MOE_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(moe_q) |-> $past(moe_set || (auto_arm && upd_evt))); // R8

endmodule

// File: rtl/cpo_deadtime.sv
// Dead-time generator for one reference.
// A reference edge reloads the counter; the off-going side drops at once and
// the on-going side waits until the counter is back to zero.
module cpo_deadtime #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_i,
    input  logic [DT_W-1:0] dt,
    input  logic            direct,
    output logic            raw_p,
    output logic            raw_n
);

    logic            ref_q;
    logic [DT_W-1:0] gap_cnt;
    logic            settled;

    // Track the reference and count down the gap after each edge of it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= 1'b0;
            gap_cnt <= '0;
        end else if (ref_i != ref_q) begin
            ref_q   <= ref_i;
            gap_cnt <= dt;
        end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end

    assign settled = direct | (gap_cnt == '0);
    assign raw_p   = ref_q  & settled;
    assign raw_n   = ~ref_q & settled;

endmodule

// File: rtl/cpo_pin_drive.sv
// Level and drive-enable selection for one pin of the pair.
// Run state uses the dead-timed raw level or the run-state off rule; idle
// state uses the idle-state off rule, showing the inactive level while the
// idle dead time is still running.
module cpo_pin_drive (
    input  logic raw,
    input  logic en,
    input  logic pol,
    input  logic idle_lvl,
    input  logic off_run,
    input  logic off_idle,
    input  logic run,
    input  logic idle_wait,
    input  logic direct,
    output logic pin,
    output logic oe
);

    // Choose pin level and enable from run/idle state and the off rules.
    always_comb begin
        pin = 1'b0;
        oe  = 1'b0;
        if (run) begin
            if (en) begin
                oe  = 1'b1;
                pin = raw ^ pol;
            end else if (off_run) begin
                oe  = 1'b1;
                pin = pol;
            end
        end else if (off_idle && en) begin
            oe  = 1'b1;
            pin = (idle_wait && !direct) ? pol : idle_lvl;
        end
    end

endmodule

// File: rtl/cpair_out_stage.sv
// Top of the complementary output stage: configuration with lock, main
// enable and break control, reference mode select, dead-time generation and
// the two pin drivers. Assumes a single clock and synchronous active-low reset.
module cpair_out_stage
    import cpo_pkg::*;
#(
    parameter int NUM_PINS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             upd_evt,
    input  logic             brk_in,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             moe_set,
    input  logic             moe_clr,
    input  logic             flag_clr,
    output logic             pin_p,
    output logic             pin_n,
    output logic             pin_p_oe,
    output logic             pin_n_oe,
    output logic             main_en,
    output logic             brk_flag
);

    cfg_t cfg;
    logic oc_ref;
    logic raw_p;
    logic raw_n;
    logic idle_wait;

    logic [NUM_PINS-1:0] v_raw;
    logic [NUM_PINS-1:0] v_en;
    logic [NUM_PINS-1:0] v_pol;
    logic [NUM_PINS-1:0] v_idle;
    logic [NUM_PINS-1:0] v_pin;
    logic [NUM_PINS-1:0] v_oe;

    cpo_cfg_regs i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_t'(cfg_wdata)),
        .cfg   (cfg)
    );

    cpo_moe_ctrl #(.DT_W(DT_W)) i_moe (
        .clk       (clk),
        .rst_n     (rst_n),
        .brk_in    (brk_in),
        .brk_en    (cfg.brk_en),
        .brk_pol   (cfg.brk_pol),
        .auto_arm  (cfg.auto_arm),
        .upd_evt   (upd_evt),
        .moe_set   (moe_set),
        .moe_clr   (moe_clr),
        .flag_clr  (flag_clr),
        .dt        (cfg.dt),
        .moe_eff   (main_en),
        .brk_flag  (brk_flag),
        .idle_wait (idle_wait)
    );

    // Select the internal reference from the output mode.
    always_comb begin
        unique case (cfg.mode)
            MODE_FOLLOW:    oc_ref = ref_in;
            MODE_INVERT:    oc_ref = ~ref_in;
            MODE_FORCE_OFF: oc_ref = 1'b0;
            MODE_FORCE_ON:  oc_ref = 1'b1;
            default:        oc_ref = 1'b0;
        endcase
    end

    cpo_deadtime #(.DT_W(DT_W)) i_dt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (oc_ref),
        .dt     (cfg.dt),
        .direct (cfg.direct),
        .raw_p  (raw_p),
        .raw_n  (raw_n)
    );

    // Gather per-pin controls; index 0 is the high side, 1 the low side.
    assign v_raw  = {raw_n, raw_p};
    assign v_en   = {cfg.en_n, cfg.en_p};
    assign v_pol  = {cfg.pol_n, cfg.pol_p};
    assign v_idle = {cfg.idle_n, cfg.idle_p};

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        cpo_pin_drive i_drv (
            .raw       (v_raw[g]),
            .en        (v_en[g]),
            .pol       (v_pol[g]),
            .idle_lvl  (v_idle[g]),
            .off_run   (cfg.off_run),
            .off_idle  (cfg.off_idle),
            .run       (main_en),
            .idle_wait (idle_wait),
            .direct    (cfg.direct),
            .pin       (v_pin[g]),
            .oe        (v_oe[g])
        );
    end

    assign pin_p    = v_pin[0];
    assign pin_n    = v_pin[1];
    assign pin_p_oe = v_oe[0];
    assign pin_n_oe = v_oe[1];

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (main_en && cfg.en_p && cfg.en_n) |->
        !((pin_p != cfg.pol_p) && (pin_n != cfg.pol_n))); // R3

    AST_L1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.lock != LOCK_NONE) |=> $stable(cfg.dt)); // R11

endmodule

// File: tb/test_cpair_out_stage.sv
module test_cpair_out_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0;
    logic        upd_evt = 1'b0;
    logic        brk_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [23:0] cfg_wdata = '0;
    logic        moe_set = 1'b0;
    logic        moe_clr = 1'b0;
    logic        flag_clr = 1'b0;
    logic        pin_p, pin_n, pin_p_oe, pin_n_oe, main_en, brk_flag;

    int n_chk = 0;
    int n_bad = 0;

    // Bench copy of the configuration fields, packed per R2.
    logic [7:0] c_dt;
    logic c_bke, c_bkp, c_aoe, c_idp, c_idn, c_pp, c_pn, c_ossr, c_ossi, c_dir, c_enp, c_enn;
    logic [1:0] c_lock, c_mode;

    cpair_out_stage i_cpair_out_stage (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .upd_evt(upd_evt), .brk_in(brk_in),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .moe_set(moe_set), .moe_clr(moe_clr),
        .flag_clr(flag_clr), .pin_p(pin_p), .pin_n(pin_n), .pin_p_oe(pin_p_oe),
        .pin_n_oe(pin_n_oe), .main_en(main_en), .brk_flag(brk_flag)
    );

    always #10 clk = ~clk;

    function automatic logic [23:0] pack_cfg();
        return {c_mode, c_enn, c_enp, c_lock, c_dir, c_ossi, c_ossr, c_pn, c_pp,
                c_idn, c_idp, c_aoe, c_bkp, c_bke, c_dt};
    endfunction

    task automatic defaults();
        c_dt = 8'd0; c_bke = 0; c_bkp = 0; c_aoe = 0; c_idp = 0; c_idn = 0;
        c_pp = 0; c_pn = 0; c_ossr = 0; c_ossi = 0; c_dir = 0; c_enp = 0; c_enn = 0;
        c_lock = 2'd0; c_mode = 2'd0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg();
        cfg_wdata = pack_cfg();
        cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_set();
        moe_set = 1'b1; step(1); moe_set = 1'b0;
    endtask

    task automatic pulse_flag_clr();
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ref_in = 0; upd_evt = 0; brk_in = 0; cfg_we = 0;
        moe_set = 0; moe_clr = 0; flag_clr = 0;
        defaults();
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 p_oe", pin_p_oe, 0);
        chk("R1 n_oe", pin_n_oe, 0);
        chk("R1 main_en", main_en, 0);
        chk("R1 brk_flag", brk_flag, 0);
        chk("R1 pin_p", pin_p, 0);
    endtask

    task automatic t_deadtime();
        c_dt = 8'd3; c_enp = 1; c_enn = 1;
        write_cfg();
        pulse_set();
        chk("R8 sw set", main_en, 1);
        chk("R2 pin_n idle ref", pin_n, 1);
        ref_in = 1'b1;
        step(1);
        chk("R3 p off first", pin_p, 0);
        chk("R3 n off first", pin_n, 0);
        step(2);
        chk("R3 p still gap", pin_p, 0);
        step(1);
        chk("R3 p on after D", pin_p, 1);
        chk("R3 n stays off", pin_n, 0);
        ref_in = 1'b0;
        step(1);
        chk("R3 both off", {pin_p, pin_n}, 2'b00);
        step(2);
        chk("R3 n still gap", pin_n, 0);
        step(1);
        chk("R3 n on after D", pin_n, 1);
    endtask

    task automatic t_direct();
        c_dir = 1;
        write_cfg();
        ref_in = 1'b1;
        step(1);
        chk("R4 direct p", {pin_p, pin_n}, 2'b10);
        ref_in = 1'b0;
        step(1);
        chk("R4 direct n", {pin_p, pin_n}, 2'b01);
        c_dir = 0;
    endtask

    task automatic t_polarity();
        c_dt = 8'd0; c_pp = 1; c_pn = 1;
        write_cfg();
        ref_in = 1'b1;
        step(1);
        chk("R5 active low p", pin_p, 0);
        chk("R5 inactive n", pin_n, 1);
        c_pp = 0; c_pn = 0;
        write_cfg();
        chk("R3 zero dead time", {pin_p, pin_n}, 2'b10);
    endtask

    task automatic t_mode();
        c_mode = 2'b01; write_cfg(); step(1);
        chk("R6 invert", {pin_p, pin_n}, 2'b01);
        c_mode = 2'b10; write_cfg(); step(1);
        chk("R6 force off", {pin_p, pin_n}, 2'b01);
        c_mode = 2'b11; write_cfg(); step(1);
        chk("R6 force on", {pin_p, pin_n}, 2'b10);
        c_mode = 2'b00; write_cfg(); step(1);
        chk("R6 follow", {pin_p, pin_n}, 2'b10);
    endtask

    task automatic t_break();
        c_dt = 8'd2; c_bke = 1; c_bkp = 1; c_ossi = 1; c_idp = 1; c_idn = 0;
        write_cfg();
        chk("R7 inactive break", main_en, 1);
        brk_in = 1'b1;
        #1;
        chk("R7 same cycle", main_en, 0);
        chk("R9 wait inactive", {pin_p, pin_n, pin_p_oe, pin_n_oe}, 4'b0011);
        step(1);
        chk("R7 flag set", brk_flag, 1);
        chk("R9 p gap 1", pin_p, 0);
        step(1);
        chk("R9 p gap 2", pin_p, 0);
        step(1);
        chk("R9 idle levels", {pin_p, pin_n, pin_p_oe}, 3'b101);
        pulse_flag_clr();
        chk("R7 clr ignored in break", brk_flag, 1);
        brk_in = 1'b0;
        upd_evt = 1'b1; step(1); upd_evt = 1'b0;
        chk("R8 no auto arm", main_en, 0);
        pulse_flag_clr();
        chk("R7 flag cleared", brk_flag, 0);
        pulse_set();
        chk("R8 rearm sw", main_en, 1);
        // active-low break
        c_bke = 0; c_bkp = 0; write_cfg();
        brk_in = 1'b1;
        c_bke = 1; write_cfg();
        chk("R7 low pol high pin", main_en, 1);
        brk_in = 1'b0;
        #1;
        chk("R7 low pol trips", main_en, 0);
        step(1);
        chk("R7 low pol flag", brk_flag, 1);
        brk_in = 1'b1;
        c_bke = 0; write_cfg();
        pulse_flag_clr();
        pulse_set();
        brk_in = 1'b0;
        #1;
        chk("R7 disabled break", main_en, 1);
        step(1);
        chk("R7 disabled no flag", brk_flag, 0);
    endtask

    task automatic t_auto();
        c_bke = 1; c_bkp = 1; c_aoe = 1;
        write_cfg();
        brk_in = 1'b1; step(1); brk_in = 1'b0; step(1);
        chk("R8 off after break", main_en, 0);
        step(2);
        chk("R8 waits for update", main_en, 0);
        upd_evt = 1'b1; step(1); upd_evt = 1'b0;
        chk("R8 auto rearm", main_en, 1);
        brk_in = 1'b1; upd_evt = 1'b1; step(1); upd_evt = 1'b0; brk_in = 1'b0;
        #1;
        chk("R8 update during break", main_en, 0);
        upd_evt = 1'b1; step(1); upd_evt = 1'b0;
        chk("R8 rearm again", main_en, 1);
        pulse_flag_clr();
    endtask

    task automatic t_idle_release();
        c_ossi = 0; write_cfg();
        moe_clr = 1'b1; step(1); moe_clr = 1'b0;
        chk("R9 released", {pin_p_oe, pin_n_oe}, 2'b00);
        pulse_set();
    endtask

    task automatic t_run_off();
        c_enp = 0; c_ossr = 1; write_cfg();
        chk("R10 drive inactive", {pin_p_oe, pin_p}, 2'b10);
        c_ossr = 0; write_cfg();
        chk("R10 released", pin_p_oe, 0);
        c_enp = 1; write_cfg();
    endtask

    task automatic t_lock();
        do_reset();
        c_dt = 8'd5; c_lock = 2'd1; c_enp = 1; c_enn = 1;
        write_cfg();
        pulse_set();
        c_dt = 8'd1; c_lock = 2'd0;
        write_cfg();
        ref_in = 1'b1;
        step(5);
        chk("R12 lock kept dt frozen", pin_p, 0);
        step(1);
        chk("R11 dt 5 held", pin_p, 1);
        c_pp = 1; write_cfg();
        chk("R11 pol open at L1", pin_p, 0);
        c_pp = 0; write_cfg();
        ref_in = 1'b0;
        step(7);
        chk("R11 settle n", pin_n, 1);
        c_lock = 2'd3; c_mode = 2'b11;
        write_cfg();
        step(6);
        chk("R12 lock not raised", pin_p, 1);
        // level 3
        do_reset();
        c_lock = 2'd3; c_enp = 1; c_enn = 1;
        write_cfg();
        pulse_set();
        ref_in = 1'b1;
        step(1);
        chk("R11 L3 base", pin_p, 1);
        c_mode = 2'b10; c_pp = 1; c_enn = 0; c_ossr = 1;
        write_cfg();
        step(1);
        chk("R11 mode pol frozen", pin_p, 1);
        chk("R11 enable open", pin_n_oe, 0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        defaults();
        t_reset();
        t_deadtime();
        t_direct();
        t_polarity();
        t_mode();
        t_break();
        t_auto();
        t_idle_release();
        t_run_off();
        t_lock();
        summary();
        $finish;
    end

endmodule